// File: doc/BRIEF.md
# UART Interrupt Identification Prioritizer

This block merges the interrupt causes of a UART into a single four-bit identification code and one request line, the value a processor sees when it reads the interrupt identification register. It watches a line-error event, the receive FIFO fill count against a selectable trigger level, a character-timeout flag from an external timer and the transmit FIFO empty status. It reports the most urgent cause that is pending.

Two causes hold their own state. A line error stays pending until the line status register is read. The transmit-empty cause is armed only after the transmit FIFO has been empty for a programmable number of clock cycles. This delay corresponds to one character time less the stop bit and gives software time to refill the FIFO after start-up or after a write. The cause is withdrawn by a write to the transmit holding register. A read of the identification register also withdraws it, but only when that read reported transmit-empty. The FIFOs, the serializer and the timeout counter sit outside the block.

Top module: `uart_irq_prio`

## Requirements
- R1: The code is 0001 when nothing is pending, 0110 for a line error, 0100 for receive data available, 1100 for character timeout and 0010 for transmit empty. Bit 0 is 0 exactly when a cause is pending.
- R2: A line error outranks the receive causes, which outrank transmit empty.
- R3: Receive data available is active while rx_count is greater than or equal to the level picked by trig_sel (0→1, 1→4, 2→8, 3→14), and inactive below it.
- R4: When receive data available and character timeout are both active, the code is 0100.
- R5: A pulse on line_err sets the line-error cause one cycle later. It stays set until a cycle with lsr_rd high and line_err low, which clears it on the next cycle. A new error in the same cycle as the read wins.
- R6: Transmit empty becomes pending on the ARM_CYCLES-th rising clock edge at which tx_empty is high, counted since reset or since the last thr_wr. It is not pending before that edge, and the count restarts whenever tx_empty is low.
- R7: thr_wr withdraws the transmit-empty cause on the next cycle and restarts the arming count.
- R8: iir_rd withdraws the transmit-empty cause only when the code presented during that read was 0010. A read that shows another code leaves it pending.
- R9: irq is high exactly when bit 0 of the code is 0.
- R10: After reset the code is 0001 and irq is low.
- R11: Once transmit empty has been withdrawn by a read, it does not return until a thr_wr is followed by a new arming period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_err | input | 1 | One-cycle pulse when a line error is detected |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_count | input | CNT_W | Receive FIFO fill count |
| trig_sel | input | 2 | Receive trigger level select |
| char_tmo | input | 1 | Character timeout flag from external timer |
| tx_empty | input | 1 | Transmit FIFO empty status |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| iir_code | output | 4 | Prioritized identification code |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case is a transmit-empty cause that is already pending while a higher cause masks it. An identification read at that moment must leave it in place. To reach this case, the bench first lets the arming period run out with receive quiet, then raises a line error and reads. It then clears the error and checks that the hidden cause reappears. After that it reads once more to withdraw the cause and waits well beyond the arming period. This shows that the cause stays away until a write starts a fresh arming count. A sweep over every trigger select, every fill count and each line-error and timeout combination covers the priority and level logic.

// File: rtl/uart_irq_pkg.sv
// Shared identification codes for the UART interrupt prioritizer.
package uart_irq_pkg;
    typedef enum logic [3:0] {
        ID_NONE = 4'b0001,
        ID_LINE = 4'b0110,
        ID_RXAV = 4'b0100,
        ID_TMO  = 4'b1100,
        ID_TXE  = 4'b0010
    } id_code_e;
endpackage

// File: rtl/rx_level_cmp.sv
// Receive-level comparator: decodes the trigger select into a character
// count and flags when the receive FIFO holds at least that many.
// Assumes CNT_W is wide enough to hold the largest level (14).
module rx_level_cmp #(
    parameter int CNT_W = 5
) (
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    output logic             rx_avail
);
    logic [CNT_W-1:0] level;

    // Map the select field to a trigger level.
    always_comb begin
        unique case (trig_sel)
            2'd0:    level = CNT_W'(1);
            2'd1:    level = CNT_W'(4);
            2'd2:    level = CNT_W'(8);
            default: level = CNT_W'(14);
        endcase
    end

    // Compare the fill count with the level.
    always_comb rx_avail = (rx_count >= level);
endmodule

// File: rtl/txe_arm.sv
// Transmit-empty arming and clear logic. Counts consecutive empty cycles
// and raises the cause once per refill after ARM_CYCLES cycles. A write
// or a qualifying identification read withdraws it.
// Assumes ARM_CYCLES >= 1.
module txe_arm #(
    parameter int ARM_CYCLES = 144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic thr_wr,
    input  logic rd_hit,
    output logic txe_pend
);
    localparam int ARM_W = $clog2(ARM_CYCLES + 1);
    localparam logic [ARM_W-1:0] ARM_LAST = ARM_W'(ARM_CYCLES - 1);

    logic [ARM_W-1:0] cnt;
    logic             fired;

    // Arm counter, one-shot flag and pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            fired    <= 1'b0;
            txe_pend <= 1'b0;
        end else if (thr_wr) begin
            cnt      <= '0;
            fired    <= 1'b0;
            txe_pend <= 1'b0;
        end else begin
            if (rd_hit)
                txe_pend <= 1'b0;
            if (!tx_empty) begin
                cnt <= '0;
            end else if (!fired) begin
                if (cnt == ARM_LAST) begin
                    fired    <= 1'b1;
                    txe_pend <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_arm_needs_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txe_pend) |-> $past(tx_empty));
    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !txe_pend);
endmodule

// File: rtl/id_encode.sv
// Priority encoder: picks the most urgent pending cause and emits its
// identification code. Receive data available wins over timeout.
module id_encode
    import uart_irq_pkg::*;
(
    input  logic     line_pend,
    input  logic     rx_avail,
    input  logic     char_tmo,
    input  logic     txe_pend,
    output id_code_e code
);
    // Fixed-priority selection.
    always_comb begin
        if (line_pend)     code = ID_LINE;
        else if (rx_avail) code = ID_RXAV;
        else if (char_tmo) code = ID_TMO;
        else if (txe_pend) code = ID_TXE;
        else               code = ID_NONE;
    end
endmodule

// File: rtl/uart_irq_prio.sv
// Top: UART interrupt identification prioritizer. Holds the line-error
// pending flag and ties the comparator, arming logic and encoder together.
// Assumes all strobes are single-cycle and synchronous to clk.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int CNT_W      = 5,
    parameter int ARM_CYCLES = 144
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_err,
    input  logic             lsr_rd,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             char_tmo,
    input  logic             tx_empty,
    input  logic             thr_wr,
    input  logic             iir_rd,
    output logic [3:0]       iir_code,
    output logic             irq
);
    logic     line_pend;
    logic     rx_avail;
    logic     txe_pend;
    logic     rd_hit;
    id_code_e code;

    // Line-error flag: a new error wins over a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)        line_pend <= 1'b0;
        else if (line_err) line_pend <= 1'b1;
        else if (lsr_rd)   line_pend <= 1'b0;
    end

    rx_level_cmp #(.CNT_W(CNT_W)) cmp_i (
        .trig_sel (trig_sel),
        .rx_count (rx_count),
        .rx_avail (rx_avail)
    );

    // A read clears transmit-empty only when it reported that cause.
    always_comb rd_hit = iir_rd && (code == ID_TXE);

    txe_arm #(.ARM_CYCLES(ARM_CYCLES)) arm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_empty (tx_empty),
        .thr_wr   (thr_wr),
        .rd_hit   (rd_hit),
        .txe_pend (txe_pend)
    );

    id_encode enc_i (
        .line_pend (line_pend),
        .rx_avail  (rx_avail),
        .char_tmo  (char_tmo),
        .txe_pend  (txe_pend),
        .code      (code)
    );

    // Drive the outputs.
    always_comb begin
        iir_code = code;
        irq      = line_pend | rx_avail | char_tmo | txe_pend;
    end

    assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        iir_code inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010});
    assert_irq_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iir_code[0]);
    assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_pend |-> iir_code == 4'b0110);
    assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pend && !lsr_rd) |=> line_pend);
    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_code == 4'b0010 && !thr_wr) |=> iir_code != 4'b0010);
endmodule

// File: tb/uart_irq_prio_tb_top.sv
module uart_irq_prio_tb_top;
    localparam int CNT_W = 5;
    localparam int ARM   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_err = 0, lsr_rd = 0, char_tmo = 0, tx_empty = 0, thr_wr = 0, iir_rd = 0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [1:0] trig_sel = '0;
    logic [3:0] iir_code;
    logic irq;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_irq_prio #(.CNT_W(CNT_W), .ARM_CYCLES(ARM)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_err(line_err), .lsr_rd(lsr_rd),
        .rx_count(rx_count), .trig_sel(trig_sel), .char_tmo(char_tmo),
        .tx_empty(tx_empty), .thr_wr(thr_wr), .iir_rd(iir_rd),
        .iir_code(iir_code), .irq(irq)
    );

    task automatic check(input string req, input logic [3:0] exp);
        total++;
        if (iir_code !== exp || irq !== !exp[0]) begin
            bad++;
            $display("FAIL %s code=%b irq=%b expected code=%b irq=%b",
                     req, iir_code, irq, exp, !exp[0]);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] expect_code(input bit ls, input int cnt,
            input int sel, input bit tmo, input bit txe);
        int lvl;
        lvl = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
        if (ls)              return 4'b0110;
        else if (cnt >= lvl) return 4'b0100;
        else if (tmo)        return 4'b1100;
        else if (txe)        return 4'b0010;
        else                 return 4'b0001;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        check("R10", 4'b0001);
        rst_n = 1'b1;
        step(1);
        check("R10", 4'b0001);

        // Sweep: R1 R2 R3 R4 R9 over line error, timeout, selects, counts.
        for (int ls = 0; ls < 2; ls++) begin
            if (ls == 1) begin
                line_err = 1; step(1); line_err = 0;
            end
            for (int tmo = 0; tmo < 2; tmo++)
                for (int sel = 0; sel < 4; sel++)
                    for (int cnt = 0; cnt <= 16; cnt++) begin
                        char_tmo = tmo[0]; trig_sel = sel[1:0];
                        rx_count = CNT_W'(cnt);
                        #1;
                        check("R3/R4/R2/R1", expect_code(ls[0], cnt, sel, tmo[0], 0));
                    end
        end
        char_tmo = 0; rx_count = '0;
        // R5: line error held without read, cleared by read, error wins over read.
        step(5);
        check("R5", 4'b0110);
        lsr_rd = 1; line_err = 1; step(1); line_err = 0;
        check("R5", 4'b0110);
        step(1); lsr_rd = 0;
        check("R5", 4'b0001);

        // R6: arming from a fresh write with tx empty.
        thr_wr = 1; tx_empty = 1; step(1); thr_wr = 0;
        step(ARM - 1);
        check("R6", 4'b0001);
        step(1);
        check("R6", 4'b0010);

        // R8: read while line error masks transmit empty leaves it pending.
        line_err = 1; step(1); line_err = 0;
        iir_rd = 1; step(1); iir_rd = 0;
        check("R8", 4'b0110);
        lsr_rd = 1; step(1); lsr_rd = 0;
        check("R8", 4'b0010);
        // R8: read reporting transmit empty clears it.
        iir_rd = 1; #1; check("R8", 4'b0010); step(1); iir_rd = 0;
        check("R8", 4'b0001);
        // R11: stays away without a write.
        step(3 * ARM);
        check("R11", 4'b0001);

        // R7: write restarts arming; write while pending clears.
        thr_wr = 1; step(1); thr_wr = 0;
        step(ARM);
        check("R7", 4'b0010);
        thr_wr = 1; step(1); thr_wr = 0;
        check("R7", 4'b0001);
        // R6: dropping tx empty restarts the count.
        step(ARM - 2);
        tx_empty = 0; step(1); tx_empty = 1;
        step(ARM - 1);
        check("R6", 4'b0001);
        step(1);
        check("R6", 4'b0010);
        // R2: receive data outranks transmit empty.
        trig_sel = 0; rx_count = 1; #1;
        check("R2", 4'b0100);
        rx_count = 0; #1;
        check("R2", 4'b0010);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule